// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a bank of 32-bit control words for a system controller, reached over a simple word-wide request/response bus that decodes a 4 KiB window. A write to a lower span of the bank only lands when a stored unlock key is nonzero. The unlock key is written through word 0. A strap word can be added to or cleared through two separate offsets. A random-data word returns a fresh pseudo-random value on every read.

At reset every word takes a default picked by the silicon generation. The revision word, both strap words and the key word are then loaded from configuration inputs, so the bank can leave reset already unlocked. The generation comes from the configured revision word: the part counts as the newer generation when bits 31:24 equal the parameter `NEWER_FAMILY`, which defaults to 8'h04.

Top module: `keyed_sysctl_regs`

## Requirements
- R1: Every request cycle (`reqValid` high) gives `rspValid` high exactly one clock later. For a read, `rspRdata` in that cycle holds the addressed word. A write to a plain word is visible to any later read.
- R2: A write to offset 0x000 stores 1 when the data equals `UNLOCK_KEY` (default 32'h1688A8A8) and stores 0 for any other value. A wrong value therefore relocks the bank. The bank counts as unlocked whenever word 0 is nonzero.
- R3: While word 0 is zero, writes to offsets 0x004 through 0x100 are dropped and answered with `rspErr`. Offsets 0x104 and up stay writable whatever the lock state.
- R4: On the newer generation, with the bank unlocked, a write to 0x070 ORs the data into the strap word. A write to 0x07C clears the strap bits that are set in the data, leaves the revision word unchanged and raises no error.
- R5: On the older generation, a write to 0x07C is rejected with `rspErr` and changes nothing. A write to 0x070 stores the data as is.
- R6: Each read of 0x078 first advances a 32-bit LFSR and then returns its new state. The LFSR starts from `LFSR_SEED` at reset and steps as next = {s[30:0], s[31]^s[21]^s[1]^s[0]}. This holds whatever the enable bits at 0x074 are.
- R7: After reset, the following words hold their defaults:
  - 0x004 = 32'hFFCFFEDC
  - 0x040 = 32'h000000C0
  - 0x074 = 32'h0000000E
  - 0x1A4 = 32'h00002402
  - 0x024 = 32'h93000400 on the newer generation and 32'h00000291 on the older one

  The following words hold their configuration inputs:
  - 0x07C holds `cfgRevId`
  - 0x070 holds `cfgStrap1`
  - 0x0D0 holds `cfgStrap2`
  - 0x000 holds `cfgKey`
- R8: A request to an offset with bits 1:0 nonzero, or at or above 4*`NUM_REGS` (0x1A8 by default), gets `rspErr` together with `rspRdata` = 0, and a write there changes no word.
- R9: A write to 0x078 is rejected with `rspErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Single-cycle request strobe |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 12 | Byte offset inside the window |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response strobe, one clock after the request |
| rspRdata | output | 32 | Read data, valid with rspValid |
| rspErr | output | 1 | Rejected or undecoded access, valid with rspValid |
| cfgRevId | input | 32 | Revision word loaded at reset |
| cfgStrap1 | input | 32 | Strap word loaded at reset |
| cfgStrap2 | input | 32 | Second strap word loaded at reset |
| cfgKey | input | 32 | Initial key word loaded at reset |

## Verification
The bench keeps `UNLOCK_KEY` and `NUM_REGS` at their defaults, so the lock boundary at 0x104 and the out-of-range edge at 0x1A8 are both reachable. It overrides `LFSR_SEED` with a word that has many bits set, so the feedback taps are exercised from the first random read. The bench resets the block once with a newer-generation revision word and once with an older-generation one. The first pass covers the OR and clear paths of the strap word. The second pass covers the rejected revision write and the differing defaults. A nonzero `cfgKey` shows that the bank can leave reset already unlocked.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int KEY_IDX    = 0;
  localparam int STRAP1_IDX = 28;  // 0x070
  localparam int RNGCTL_IDX = 29;  // 0x074
  localparam int RNGDAT_IDX = 30;  // 0x078
  localparam int REV_IDX    = 31;  // 0x07C
  localparam int STRAP2_IDX = 52;  // 0x0D0
  localparam int OPEN_IDX   = 65;  // 0x104, first word outside the lock

  typedef struct packed {
    logic plainWr;
    logic keyWr;
    logic keyMatch;
    logic strapOr;
    logic strapClr;
    logic rdReg;
    logic rdRng;
  } strobe_t;

  function automatic logic [31:0] resetWord(input int idx, input logic newer);
    logic [31:0] w;
    w = 32'h0;
    case (idx)
      1:   w = 32'hFFCFFEDC;
      2:   w = 32'hF3F40000;
      3:   w = 32'h19FC3E8B;
      7:   w = 32'h00026108;
      8:   w = 32'h00030291;
      9:   w = newer ? 32'h93000400 : 32'h00000291;
      11:  w = 32'h00000010;
      12:  w = 32'h20001A03;
      13:  w = 32'h20001A03;
      14:  w = 32'h04000030;
      15:  w = 32'h00000001;
      16:  w = 32'h000000C0;
      19:  w = 32'h00000023;
      29:  w = 32'h0000000E;
      33:  w = 32'h0000F000;
      34:  w = newer ? 32'h03000000 : 32'h01000000;
      35:  w = newer ? 32'h00000000 : 32'h000000FF;
      36:  w = 32'h0000A000;
      39:  w = newer ? 32'h023FFFF3 : 32'h003FFFF3;
      41:  w = 32'hFFFF0000;
      42:  w = 32'h000FFFFF;
      56:  w = 32'h000000FF;
      57:  w = 32'h000000FF;
      65:  w = 32'h80000000;
      68:  w = 32'h1E600000;
      69:  w = 32'hC0000000;
      88:  w = 32'h00001903;
      96:  w = 32'h0000007B;
      105: w = 32'h00002402;
      default: w = 32'h0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int          WINDOW_BYTES = 4096,
  parameter int          NUM_REGS     = 106,
  parameter logic [31:0] UNLOCK_KEY   = 32'h1688A8A8,
  localparam int ADDR_W = $clog2(WINDOW_BYTES),
  localparam int WI_W   = ADDR_W - 2,
  localparam int IDX_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic              keyOpen,
  input  logic              newerRev,
  output strobe_t           stb,
  output logic [IDX_W-1:0]  idx,
  output logic              rspValid,
  output logic              rspErr
);

  localparam logic [WI_W-1:0] LIMIT_W  = WI_W'(NUM_REGS);
  localparam logic [WI_W-1:0] KEY_W    = WI_W'(KEY_IDX);
  localparam logic [WI_W-1:0] OPEN_W   = WI_W'(OPEN_IDX);
  localparam logic [WI_W-1:0] STRAP1_W = WI_W'(STRAP1_IDX);
  localparam logic [WI_W-1:0] RNGDAT_W = WI_W'(RNGDAT_IDX);
  localparam logic [WI_W-1:0] REV_W    = WI_W'(REV_IDX);

  logic [WI_W-1:0] wordIdx;
  logic            inRange;
  logic            lockedSpan;
  logic            reject;

  assign wordIdx    = reqAddr[ADDR_W-1:2];
  assign inRange    = (reqAddr[1:0] == 2'b00) && (wordIdx < LIMIT_W);
  assign lockedSpan = (wordIdx > KEY_W) && (wordIdx < OPEN_W);
  assign idx        = wordIdx[IDX_W-1:0];

  always_comb begin
    stb    = '0;
    reject = 1'b0;
    if (reqValid) begin
      if (!inRange) begin
        reject = 1'b1;
      end else if (reqWrite) begin
        if (wordIdx == KEY_W) begin
          stb.keyWr    = 1'b1;
          stb.keyMatch = (reqWdata == UNLOCK_KEY);
        end else if (lockedSpan && !keyOpen) begin
          reject = 1'b1;
        end else if (wordIdx == RNGDAT_W) begin
          reject = 1'b1;
        end else if (wordIdx == REV_W) begin
          if (newerRev) stb.strapClr = 1'b1;
          else          reject       = 1'b1;
        end else if (wordIdx == STRAP1_W && newerRev) begin
          stb.strapOr = 1'b1;
        end else begin
          stb.plainWr = 1'b1;
        end
      end else begin
        if (wordIdx == RNGDAT_W) stb.rdRng = 1'b1;
        else                     stb.rdReg = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= reqValid && reject;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);  // R1

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid && !rspErr);  // R1

  AST_LOCK_REJECTS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && inRange && lockedSpan && !keyOpen) |=> rspErr);  // R3

  AST_RANGE_ERR: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !inRange) |=> rspErr);  // R8

endmodule

// File: rtl/sysctl_datapath.sv
module sysctl_datapath
  import sysctl_pkg::*;
#(
  parameter int          NUM_REGS     = 106,
  parameter logic [31:0] LFSR_SEED    = 32'h0000_0001,
  parameter logic [7:0]  NEWER_FAMILY = 8'h04,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  input  logic [31:0]      cfgRevId,
  input  logic [31:0]      cfgStrap1,
  input  logic [31:0]      cfgStrap2,
  input  logic [31:0]      cfgKey,
  output logic             keyOpen,
  output logic             newerRev,
  output logic [31:0]      rspRdata
);

  logic [31:0] regs [NUM_REGS];
  logic [31:0] lfsr;
  logic [31:0] lfsrNext;
  logic        cfgNewer;
  logic        armed;

  assign cfgNewer = (cfgRevId[31:24] == NEWER_FAMILY);
  assign newerRev = (regs[REV_IDX][31:24] == NEWER_FAMILY);
  assign keyOpen  = (regs[KEY_IDX] != 32'h0);
  assign lfsrNext = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        regs[i] <= resetWord(i, cfgNewer);
      end
      regs[REV_IDX]    <= cfgRevId;
      regs[STRAP1_IDX] <= cfgStrap1;
      regs[STRAP2_IDX] <= cfgStrap2;
      regs[KEY_IDX]    <= cfgKey;
    end else begin
      if (stb.keyWr)    regs[KEY_IDX]    <= {31'h0, stb.keyMatch};
      if (stb.strapOr)  regs[STRAP1_IDX] <= regs[STRAP1_IDX] | wdata;
      if (stb.strapClr) regs[STRAP1_IDX] <= regs[STRAP1_IDX] & ~wdata;
      if (stb.plainWr)  regs[idx]        <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lfsr     <= LFSR_SEED;
      rspRdata <= 32'h0;
      armed    <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (stb.rdRng) begin
        lfsr     <= lfsrNext;
        rspRdata <= lfsrNext;
      end else if (stb.rdReg) begin
        rspRdata <= regs[idx];
      end else begin
        rspRdata <= 32'h0;
      end
    end
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> lfsr != 32'h0);  // R6

  AST_RNG_FRESH: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdRng |=> (rspRdata == lfsr) && (lfsr != $past(lfsr)));  // R6

  AST_REV_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> $stable(regs[REV_IDX]));  // R4

  AST_KEY_BINARY: assert property (@(posedge clk) disable iff (!rstN)
    stb.keyWr |=> regs[KEY_IDX][31:1] == 31'h0);  // R2

endmodule

// File: rtl/keyed_sysctl_regs.sv
module keyed_sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int          WINDOW_BYTES = 4096,
  parameter int          NUM_REGS     = 106,
  parameter logic [31:0] UNLOCK_KEY   = 32'h1688A8A8,
  parameter logic [31:0] LFSR_SEED    = 32'h0000_0001,
  parameter logic [7:0]  NEWER_FAMILY = 8'h04,
  localparam int ADDR_W = $clog2(WINDOW_BYTES),
  localparam int IDX_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              rspErr,
  input  logic [31:0]       cfgRevId,
  input  logic [31:0]       cfgStrap1,
  input  logic [31:0]       cfgStrap2,
  input  logic [31:0]       cfgKey
);

  strobe_t          stb;
  logic [IDX_W-1:0] idx;
  logic             keyOpen;
  logic             newerRev;

  sysctl_ctrl #(
    .WINDOW_BYTES(WINDOW_BYTES),
    .NUM_REGS    (NUM_REGS),
    .UNLOCK_KEY  (UNLOCK_KEY)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .keyOpen (keyOpen),
    .newerRev(newerRev),
    .stb     (stb),
    .idx     (idx),
    .rspValid(rspValid),
    .rspErr  (rspErr)
  );

  sysctl_datapath #(
    .NUM_REGS    (NUM_REGS),
    .LFSR_SEED   (LFSR_SEED),
    .NEWER_FAMILY(NEWER_FAMILY)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .idx      (idx),
    .wdata    (reqWdata),
    .cfgRevId (cfgRevId),
    .cfgStrap1(cfgStrap1),
    .cfgStrap2(cfgStrap2),
    .cfgKey   (cfgKey),
    .keyOpen  (keyOpen),
    .newerRev (newerRev),
    .rspRdata (rspRdata)
  );

endmodule

// File: tb/sim_keyed_sysctl_regs.sv
`timescale 1ns/1ps
module sim_keyed_sysctl_regs;

  localparam logic [31:0] KEY  = 32'h1688A8A8;
  localparam logic [31:0] SEED = 32'hC0DE5EED;
  localparam logic [31:0] REV_NEW = 32'h04010303;
  localparam logic [31:0] REV_OLD = 32'h02010303;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspRdata;
  logic        rspErr;
  logic [31:0] cfgRevId = REV_NEW;
  logic [31:0] cfgStrap1 = '0;
  logic [31:0] cfgStrap2 = '0;
  logic [31:0] cfgKey = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  keyed_sysctl_regs #(.LFSR_SEED(SEED)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .rspValid(rspValid),
    .rspRdata(rspRdata), .rspErr(rspErr), .cfgRevId(cfgRevId),
    .cfgStrap1(cfgStrap1), .cfgStrap2(cfgStrap2), .cfgKey(cfgKey)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [31:0] rev, input logic [31:0] s1,
                         input logic [31:0] s2, input logic [31:0] k);
    @(negedge clk);
    cfgRevId = rev; cfgStrap1 = s1; cfgStrap2 = s2; cfgKey = k;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d, output logic e);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    chk("R1 write response valid", {31'h0, rspValid}, 32'h1);
    e = rspErr;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqWdata = '0;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R1 read response valid", {31'h0, rspValid}, 32'h1);
    d = rspRdata;
    e = rspErr;
  endtask

  task automatic expectRead(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic e;
    busRead(a, d, e);
    chk(req, d, exp);
    chk({req, " no error"}, {31'h0, e}, 32'h0);
  endtask

  function automatic logic [31:0] lfsrStep(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic testResetNewer();
    doReset(REV_NEW, 32'h000000A5, 32'h00C0FFEE, 32'h0);
    chk("R1 idle after reset", {31'h0, rspValid}, 32'h0);
    expectRead("R7 sysreset default", 12'h004, 32'hFFCFFEDC);
    expectRead("R7 scratch default", 12'h040, 32'h000000C0);
    expectRead("R7 rng control default", 12'h074, 32'h0000000E);
    expectRead("R7 device id default", 12'h1A4, 32'h00002402);
    expectRead("R7 newer pll default", 12'h024, 32'h93000400);
    expectRead("R7 revision from input", 12'h07C, REV_NEW);
    expectRead("R7 strap1 from input", 12'h070, 32'h000000A5);
    expectRead("R7 strap2 from input", 12'h0D0, 32'h00C0FFEE);
    expectRead("R7 key from input", 12'h000, 32'h0);
  endtask

  task automatic testLock();
    logic e;
    busWrite(12'h004, 32'h12345678, e);
    chk("R3 locked write error", {31'h0, e}, 32'h1);
    expectRead("R3 locked word unchanged", 12'h004, 32'hFFCFFEDC);
    busWrite(12'h100, 32'h55AA55AA, e);
    chk("R3 last locked word error", {31'h0, e}, 32'h1);
    expectRead("R3 last locked word unchanged", 12'h100, 32'h0);
    busWrite(12'h104, 32'hDEADBEEF, e);
    chk("R3 open word no error", {31'h0, e}, 32'h0);
    expectRead("R3 open word written while locked", 12'h104, 32'hDEADBEEF);
  endtask

  task automatic testKey();
    logic e;
    busWrite(12'h000, KEY ^ 32'h1, e);
    chk("R2 wrong key no error", {31'h0, e}, 32'h0);
    expectRead("R2 wrong key stores 0", 12'h000, 32'h0);
    busWrite(12'h000, KEY, e);
    expectRead("R2 key stores 1", 12'h000, 32'h1);
    busWrite(12'h004, 32'h12345678, e);
    chk("R2 unlocked write no error", {31'h0, e}, 32'h0);
    expectRead("R2 unlocked write lands", 12'h004, 32'h12345678);
    busWrite(12'h000, 32'h0BAD0BAD, e);
    expectRead("R2 wrong value relocks", 12'h000, 32'h0);
    busWrite(12'h004, 32'h0, e);
    chk("R2 relocked write error", {31'h0, e}, 32'h1);
    expectRead("R2 relocked word unchanged", 12'h004, 32'h12345678);
  endtask

  task automatic testStrapNewer();
    logic e;
    busWrite(12'h000, KEY, e);
    busWrite(12'h070, 32'h00000F00, e);
    chk("R4 strap set no error", {31'h0, e}, 32'h0);
    expectRead("R4 strap OR", 12'h070, 32'h00000FA5);
    busWrite(12'h07C, 32'h00000105, e);
    chk("R4 strap clear no error", {31'h0, e}, 32'h0);
    expectRead("R4 strap cleared", 12'h070, 32'h00000EA0);
    expectRead("R4 revision unchanged", 12'h07C, REV_NEW);
  endtask

  task automatic testErrors();
    logic [31:0] d;
    logic e;
    busRead(12'h1A8, d, e);
    chk("R8 out of range read data", d, 32'h0);
    chk("R8 out of range read error", {31'h0, e}, 32'h1);
    busRead(12'h006, d, e);
    chk("R8 misaligned read data", d, 32'h0);
    chk("R8 misaligned read error", {31'h0, e}, 32'h1);
    busWrite(12'h105, 32'h11111111, e);
    chk("R8 misaligned write error", {31'h0, e}, 32'h1);
    expectRead("R8 misaligned write no effect", 12'h104, 32'hDEADBEEF);
    busWrite(12'hFFC, 32'h22222222, e);
    chk("R8 top of window write error", {31'h0, e}, 32'h1);
    busWrite(12'h078, 32'h33333333, e);
    chk("R9 rng data write error", {31'h0, e}, 32'h1);
  endtask

  task automatic testOlder();
    logic e;
    doReset(REV_OLD, 32'h0000F0F0, 32'h0, 32'h00000005);
    expectRead("R7 key loaded nonzero", 12'h000, 32'h00000005);
    expectRead("R7 older pll default", 12'h024, 32'h00000291);
    busWrite(12'h004, 32'hA5A5A5A5, e);
    chk("R7 unlocked from reset", {31'h0, e}, 32'h0);
    busWrite(12'h07C, 32'h0000FFFF, e);
    chk("R5 revision write rejected", {31'h0, e}, 32'h1);
    expectRead("R5 revision unchanged", 12'h07C, REV_OLD);
    expectRead("R5 strap unchanged", 12'h070, 32'h0000F0F0);
    busWrite(12'h070, 32'h00000012, e);
    chk("R5 strap direct no error", {31'h0, e}, 32'h0);
    expectRead("R5 strap stored directly", 12'h070, 32'h00000012);
  endtask

  task automatic testRng();
    logic [31:0] model;
    logic e;
    model = SEED;
    busWrite(12'h074, 32'h0, e);
    expectRead("R6 rng enable cleared", 12'h074, 32'h0);
    for (int i = 0; i < 4; i++) begin
      model = lfsrStep(model);
      expectRead("R6 rng fresh word", 12'h078, model);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    testResetNewer();
    testLock();
    testKey();
    testStrapNewer();
    testErrors();
    testOlder();
    testRng();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule